// File: doc/BRIEF.md
# Interrupt-Capable Parallel I/O Port

This block is a bank of general-purpose pins that software drives and watches through a small memory-mapped register bus. Each pin carries an output value and a direction bit. It also has an input path that passes through a two-stage synchronizer. Software changes output levels only by writing masks to a write-one-to-set word and a write-one-to-clear word. Pins it does not name in a mask keep their level, so two agents can update different pins without a read-modify-write race.

Each pin also has a trigger detector. Three configuration bits per pin select the trigger: a sense-type bit (edge or level), a dual-edge bit and a polarity bit. Together they give rising edge, falling edge, either edge, active-high level or active-low level. Edge hits latch in a raw status word until software acknowledges them. Level hits follow the pin. An enable word gates what gets recorded. A mask word then hides recorded bits from the single combined interrupt line. The read data path is combinational, so a read returns data in the same cycle that the read enable is high.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, and every register reads 0 while the pins are held low.
- R2: A write to the set word at offset 0x0C drives high each pin whose data bit is 1. A write to the clear word at offset 0x10 drives low each pin whose data bit is 1. Zero bits leave pins unchanged. The output word at offset 0x00 reads back the current output levels, and writes to it are ignored.
- R3: The direction word at offset 0x04 is read/write. Bit value 1 makes that pin an output, and `pin_oe` equals the stored word.
- R4: The pin word at offset 0x08 returns the synchronized pin level, whatever the direction. A pin change becomes visible there after the second rising clock edge, and not after the first.
- R5: With sense-type bit 0 (word at 0x28) and dual-edge bit 0 (word at 0x2C), polarity bit 0 (word at 0x30) latches raw status on a rising transition and polarity bit 1 latches it on a falling transition. The raw status word is at offset 0x1C, and it is updated on the third rising edge after the pin change.
- R6: With sense-type bit 0 and dual-edge bit 1, both transitions latch raw status, and the polarity bit has no effect.
- R7: With sense-type bit 1, raw status follows the pin: active while the pin is high for polarity 0, and while the pin is low for polarity 1. Acknowledging a level pin has no lasting effect while the level is still active.
- R8: Raw status becomes set only for pins whose bit in the enable word (offset 0x14) is 1.
- R9: Writing 1s to the acknowledge word (offset 0x24) clears those latched edge status bits. If a new edge arrives in the same cycle as the acknowledge, the new edge wins and the bit stays set.
- R10: The masked status word (offset 0x20) equals raw AND enable AND NOT mask, where the mask word is at offset 0x18. `irq` is high exactly when any masked bit is 1.
- R11: `bus_rdata` is 0 when `bus_re` is low, and it is 0 for an offset that holds no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_wdata | input | NPINS | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | NPINS | Read data |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Output levels toward the pads |
| pin_oe | output | NPINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with 8 pins and a 6-bit address. With only 8 pins, every pin can be walked through all five trigger configurations in both directions of transition. Set and clear can be swept over many full-width masks, and enable and mask can be swept together against a latched status pattern, with every expected word computed arithmetically. The small width also makes it cheap to line up an acknowledge with the exact edge on which a new event latches, and to count the synchronizer latency one edge at a time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    // byte offsets of the register words
    localparam int OFS_OUT    = 'h00;
    localparam int OFS_DIR    = 'h04;
    localparam int OFS_PIN    = 'h08;
    localparam int OFS_SET    = 'h0C;
    localparam int OFS_CLR    = 'h10;
    localparam int OFS_IEN    = 'h14;
    localparam int OFS_MASK   = 'h18;
    localparam int OFS_RAW    = 'h1C;
    localparam int OFS_MST    = 'h20;
    localparam int OFS_ACK    = 'h24;
    localparam int OFS_SENSE  = 'h28;
    localparam int OFS_DUAL   = 'h2C;
    localparam int OFS_POLAR  = 'h30;
    localparam int OFS_LAST   = OFS_POLAR;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = pin_raw;
        st_d.stable = st_q.meta;
        st_d.last   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.stable;
    assign lvl_prev = st_q.last;
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det #(
    parameter int W = 32
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] sense_lvl,
    input  logic [W-1:0] dual_edge,
    input  logic [W-1:0] polar,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, level_hit, edge_hit;
        assign rise      = lvl[i] & ~lvl_prev[i];
        assign fall      = ~lvl[i] & lvl_prev[i];
        assign level_hit = lvl[i] ^ polar[i];
        assign edge_hit  = dual_edge[i] ? (rise | fall)
                                        : (polar[i] ? fall : rise);
        assign hit[i]    = sense_lvl[i] ? level_hit : edge_hit;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  lvl,
    input  logic [W-1:0]  hit,
    output logic [W-1:0]  out_v,
    output logic [W-1:0]  dir_v,
    output logic [W-1:0]  ien_v,
    output logic [W-1:0]  raw_v,
    output logic [W-1:0]  sense_v,
    output logic [W-1:0]  dual_v,
    output logic [W-1:0]  polar_v,
    output logic          irq
);
    typedef struct packed {
        logic [W-1:0] outv;
        logic [W-1:0] dir;
        logic [W-1:0] ien;
        logic [W-1:0] mask;
        logic [W-1:0] raw;
        logic [W-1:0] sense;
        logic [W-1:0] dual;
        logic [W-1:0] polar;
    } regs_t;

    regs_t        r_d, r_q;
    logic [W-1:0] ack_bits;
    logic [W-1:0] new_hits;
    logic [W-1:0] masked;

    function automatic logic sel(input logic [AW-1:0] a, input int ofs);
        return a == AW'(ofs);
    endfunction

    always_comb begin
        r_d      = r_q;
        ack_bits = '0;
        if (bus_we) begin
            if (sel(bus_addr, OFS_SET))   r_d.outv  = r_q.outv | bus_wdata;
            if (sel(bus_addr, OFS_CLR))   r_d.outv  = r_q.outv & ~bus_wdata;
            if (sel(bus_addr, OFS_DIR))   r_d.dir   = bus_wdata;
            if (sel(bus_addr, OFS_IEN))   r_d.ien   = bus_wdata;
            if (sel(bus_addr, OFS_MASK))  r_d.mask  = bus_wdata;
            if (sel(bus_addr, OFS_SENSE)) r_d.sense = bus_wdata;
            if (sel(bus_addr, OFS_DUAL))  r_d.dual  = bus_wdata;
            if (sel(bus_addr, OFS_POLAR)) r_d.polar = bus_wdata;
            if (sel(bus_addr, OFS_ACK))   ack_bits  = bus_wdata;
        end
        new_hits = hit & r_q.ien;
        // level pins track the live hit; edge pins latch until acknowledged,
        // and a fresh edge outranks an acknowledge in the same cycle
        r_d.raw = (r_q.sense & new_hits)
                | (~r_q.sense & ((r_q.raw & ~ack_bits) | new_hits));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign masked = r_q.raw & r_q.ien & ~r_q.mask;
    assign irq    = |masked;

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                AW'(OFS_OUT):   bus_rdata = r_q.outv;
                AW'(OFS_DIR):   bus_rdata = r_q.dir;
                AW'(OFS_PIN):   bus_rdata = lvl;
                AW'(OFS_IEN):   bus_rdata = r_q.ien;
                AW'(OFS_MASK):  bus_rdata = r_q.mask;
                AW'(OFS_RAW):   bus_rdata = r_q.raw;
                AW'(OFS_MST):   bus_rdata = masked;
                AW'(OFS_SENSE): bus_rdata = r_q.sense;
                AW'(OFS_DUAL):  bus_rdata = r_q.dual;
                AW'(OFS_POLAR): bus_rdata = r_q.polar;
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign out_v   = r_q.outv;
    assign dir_v   = r_q.dir;
    assign ien_v   = r_q.ien;
    assign raw_v   = r_q.raw;
    assign sense_v = r_q.sense;
    assign dual_v  = r_q.dual;
    assign polar_v = r_q.polar;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    logic [NPINS-1:0] lvl, lvl_prev, hit;
    logic [NPINS-1:0] ien_v, raw_st, sense_v, dual_v, polar_v;

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
        .lvl(lvl), .lvl_prev(lvl_prev)
    );

    gpio_trig_det #(.W(NPINS)) u_det (
        .lvl(lvl), .lvl_prev(lvl_prev), .sense_lvl(sense_v),
        .dual_edge(dual_v), .polar(polar_v), .hit(hit)
    );

    gpio_regs #(.W(NPINS), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .lvl(lvl), .hit(hit),
        .out_v(pin_out), .dir_v(pin_oe), .ien_v(ien_v), .raw_v(raw_st),
        .sense_v(sense_v), .dual_v(dual_v), .polar_v(polar_v),
        .irq(irq)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic             bus_we,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] raw_st,
    input logic [NPINS-1:0] ien_v
);
    logic wr_set, wr_clr, wr_dir;
    assign wr_set = bus_we && bus_addr == AW'(OFS_SET);
    assign wr_clr = bus_we && bus_addr == AW'(OFS_CLR);
    assign wr_dir = bus_we && bus_addr == AW'(OFS_DIR);

    p_set_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    p_raw_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_st & ~$past(raw_st) & ~$past(ien_v)) == '0);

    p_irq_has_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_st != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
    .raw_st(raw_st), .ien_v(ien_v)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
    localparam int N  = 8;
    localparam int AW = 6;
    localparam logic [N-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.NPINS(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int ofs, input logic [N-1:0] d);
        bus_addr = AW'(ofs); bus_wdata = d; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [N-1:0] d);
        bus_addr = AW'(ofs); bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    // expected trigger hits for mode m: 0 rise,1 fall,2 both,3 high,4 low
    function automatic logic [N-1:0] hits(input int m, input logic [N-1:0] o, input logic [N-1:0] n);
        case (m)
            0: return n & ~o;
            1: return o & ~n;
            2: return o ^ n;
            3: return n;
            default: return ~n;
        endcase
    endfunction

    function automatic string tag(input int m);
        return (m < 2) ? "R5" : (m == 2) ? "R6" : "R7";
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] v, exp_out, base, en, mk, old_p;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state, R11 unmapped offsets read 0
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 64; a += 4) begin
            rd(a, v);
            check((a > 'h30) ? "R11 unmapped" : "R1 reg", v, 0);
        end
        bus_addr = AW'('h08); pin_in = ALL; tick(3);
        #1 check("R11 re low", bus_rdata, 0);
        pin_in = '0; tick(3);

        // R2 set/clear sweep
        exp_out = '0;
        for (int i = 0; i < 16; i++) begin
            logic [N-1:0] s, c;
            s = N'(i * 37 + 5);
            c = N'(i * 73 + 11);
            wr('h0C, s); exp_out = exp_out | s;
            check("R2 set", pin_out, exp_out);
            wr('h10, c); exp_out = exp_out & ~c;
            check("R2 clr", pin_out, exp_out);
        end
        wr('h00, ~exp_out);
        rd('h00, v);
        check("R2 out word write ignored", v, exp_out);

        // R3 direction
        wr('h04, 8'h3C);
        check("R3 pin_oe", pin_oe, 8'h3C);
        rd('h04, v); check("R3 readback", v, 8'h3C);

        // R4 input latency, direction irrelevant
        pin_in = 8'h5A;
        tick(1); rd('h08, v); check("R4 after one edge", v, 0);
        tick(1); rd('h08, v); check("R4 after two edges", v, 8'h5A);
        pin_in = '0; tick(3);

        // R5 R6 R7 trigger sweep over every mode and pin
        wr('h14, ALL); wr('h18, '0);
        for (int m = 0; m < 5; m++) begin
            wr('h28, (m >= 3) ? ALL : '0);
            wr('h2C, (m == 2) ? ALL : '0);
            wr('h30, (m == 1 || m == 2 || m == 4) ? ALL : '0);
            tick(4);
            wr('h24, ALL);
            tick(1);
            rd('h1C, v);
            check({tag(m), " after ack"}, v, (m == 4) ? ALL : '0);
            for (int p = 0; p < N; p++) begin
                base = v;
                old_p = pin_in;
                pin_in = N'(1) << p;
                tick(3); rd('h1C, v);
                check({tag(m), " pin set"}, v,
                      (m >= 3) ? hits(m, old_p, pin_in) : (base | hits(m, old_p, pin_in)));
                base = v;
                old_p = pin_in;
                pin_in = '0;
                tick(3); rd('h1C, v);
                check({tag(m), " pin back"}, v,
                      (m >= 3) ? hits(m, old_p, pin_in) : (base | hits(m, old_p, pin_in)));
                wr('h24, ALL);
                rd('h1C, v);
            end
        end

        // R8 only enabled pins record
        wr('h28, '0); wr('h2C, '0); wr('h30, '0);
        wr('h14, 8'h0F); wr('h24, ALL);
        pin_in = ALL; tick(3);
        rd('h1C, v); check("R8 enabled only", v, 8'h0F);
        pin_in = '0; tick(3);
        rd('h1C, v); check("R8 rise only latched", v, 8'h0F);

        // R10 masked status and irq over enable/mask sweep
        for (int j = 0; j < 16; j++) begin
            en = N'(j * 37); mk = N'(j * 91);
            wr('h14, en); wr('h18, mk);
            rd('h20, v);
            check("R10 masked", v, 8'h0F & en & ~mk);
            check("R10 irq", irq, ((8'h0F & en & ~mk) != 0));
        end

        // R9 acknowledge and same-cycle collision
        wr('h14, ALL); wr('h18, '0);
        wr('h24, 8'h03);
        rd('h1C, v); check("R9 ack clears", v, 8'h0C);
        pin_in = 8'h10;
        tick(2);
        wr('h24, 8'h14);
        rd('h1C, v); check("R9 new edge wins", v, 8'h18);
        check("R10 irq on", irq, 1);
        wr('h24, ALL);
        check("R9 all cleared irq", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule